// File: doc/BRIEF.md
# PWM Carrier Interrupt Decimator

This block reduces the rate of carrier-period interrupts coming from a three-phase PWM timer. It watches a stream of count events and raises a one-cycle interrupt request once every n events, where n is a value written through a simple write strobe. The count event is either the carrier timer underflow pulse or a chosen edge of a reload control signal. The choice depends on a mode bit and two select bits.

The first interrupt after the block is enabled arrives one event early, after n-1 events. Every later interrupt arrives after a full n events. The written value acts as a preload. The counter takes a copy of it at the first counted event of each period, so a write made in the middle of a period only changes the periods that follow. When the function enable is low, the block counts nothing and returns to its first-period state.

Top module: `pwm_irq_decimator`

## Requirements
- R1: With mode_i = 0, each cycle with carrier_uf_i = 1 is one count event; src_sel_i, edge_sel_i and reload_ctl_i have no effect on irq_o.
- R2: With mode_i = 1 and src_sel_i = 0, each cycle with carrier_uf_i = 1 is one count event; reload_ctl_i and edge_sel_i have no effect.
- R3: With mode_i = 1, src_sel_i = 1 and edge_sel_i = 0, a count event is a cycle where reload_ctl_i is 1 and was 0 at the previous clock edge; carrier_uf_i has no effect.
- R4: With mode_i = 1, src_sel_i = 1 and edge_sel_i = 1, a count event is a cycle where reload_ctl_i is 0 and was 1 at the previous clock edge.
- R5: With a reload value n of 2 or more, the first irq_o after enable comes on the (n-1)th counted event, and each later one comes after n further events.
- R6: A reload value of 1 makes every counted event raise irq_o, including the first. A value of 0 behaves exactly like 1.
- R7: irq_o is high for exactly the cycles in which a count event completes a period, in the same cycle as that event. It is never high without an event.
- R8: While enable_i is 0, irq_o stays 0 and no events are counted. After enable_i returns to 1, the first period is again n-1 events.
- R9: wr_en_i stores wr_data_i at the clock edge. The counter samples the stored value at the first counted event of each period, so a write made during a period leaves that period's length unchanged.
- R10: After reset, irq_o is 0, the reload value is 0, and the counter is in its first-period state with no events counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Function enable; 0 clears the counter |
| mode_i | input | 1 | 0: count carrier underflow only; 1: use src_sel_i |
| src_sel_i | input | 1 | Mode 1 source: 0 underflow, 1 reload-control edge |
| edge_sel_i | input | 1 | Edge choice: 0 rising, 1 falling |
| carrier_uf_i | input | 1 | Carrier timer underflow pulse |
| reload_ctl_i | input | 1 | Reload control signal, system clock domain |
| wr_en_i | input | 1 | Write strobe for the reload value |
| wr_data_i | input | CNT_W | Reload value n |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The bench checks the short first period against the full later periods. If a design used n events for the first period, its first interrupt would come one event late. If it used n-1 events for every period, every interrupt would drift early. Reload values 1 and 0 are driven with back-to-back events. A design that decremented below zero or loaded a zero length would miss pulses or wrap around to 255 events. The bench also writes the reload value in the middle of a period, toggles the enable while a count is partly done, and drives the select bits that should be ignored. This exposes a design that applies a write at once, keeps a partial count across a disable, or mixes in the edge detector or the underflow pulse when that source is not selected.

// File: rtl/pwm_dec_pkg.sv
package pwm_dec_pkg;
  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_SELECT = 1'b1
  } dec_mode_e;

  typedef enum logic {
    SRC_UNDERFLOW = 1'b0,
    SRC_CTL_EDGE  = 1'b1
  } dec_src_e;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } dec_edge_e;
endpackage

// File: rtl/pwm_dec_evt_sel.sv
module pwm_dec_evt_sel
  import pwm_dec_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic mode_i,
  input  logic src_sel_i,
  input  logic edge_sel_i,
  input  logic carrier_uf_i,
  input  logic reload_ctl_i,
  output logic evt_o
);
  logic ctl_q;
  logic valid_q;
  logic rise, fall, edge_evt;

  // previous sample tracked regardless of enable so enabling never fakes an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      ctl_q   <= reload_ctl_i;
      valid_q <= 1'b1;
    end
  end

  assign rise     = reload_ctl_i & ~ctl_q;
  assign fall     = ~reload_ctl_i & ctl_q;
  assign edge_evt = (dec_edge_e'(edge_sel_i) == EDGE_FALL) ? fall : rise;

  always_comb begin
    evt_o = 1'b0;
    if (enable_i) begin
      if (dec_mode_e'(mode_i) == MODE_DIRECT)             evt_o = carrier_uf_i;
      else if (dec_src_e'(src_sel_i) == SRC_UNDERFLOW)    evt_o = carrier_uf_i;
      else                                                evt_o = edge_evt;
    end
  end

  AST_RISE_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni || !valid_q)
    (enable_i && mode_i && src_sel_i && !edge_sel_i && evt_o)
      |-> (reload_ctl_i && !$past(reload_ctl_i))); // R3

  AST_FALL_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni || !valid_q)
    (enable_i && mode_i && src_sel_i && edge_sel_i && evt_o)
      |-> (!reload_ctl_i && $past(reload_ctl_i))); // R4

  AST_UF_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && (!mode_i || !src_sel_i)) |-> carrier_uf_i); // R2
endmodule

// File: rtl/pwm_dec_reload.sv
module pwm_dec_reload #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] len_full_o,
  output logic [CNT_W-1:0] len_first_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      reload_q <= '0;
    else if (wr_en_i) reload_q <= wr_data_i;
  end

  // zero is treated as one; first period is one shorter but never empty
  assign len_full_o  = (reload_q == '0) ? ONE : reload_q;
  assign len_first_o = (len_full_o == ONE) ? ONE : len_full_o - ONE;
endmodule

// File: rtl/pwm_dec_count.sv
module pwm_dec_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] len_full_i,
  input  logic [CNT_W-1:0] len_first_i,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] rem_q, rem_d;
  logic             first_q, first_d;
  logic [CNT_W-1:0] start_len;

  assign start_len = first_q ? len_first_i : len_full_i;

  // rem_q == 0 means no period in progress; length is sampled at its first event
  always_comb begin
    rem_d   = rem_q;
    first_d = first_q;
    irq_o   = 1'b0;
    if (!enable_i) begin
      rem_d   = '0;
      first_d = 1'b1;
    end else if (evt_i) begin
      if (rem_q == '0) begin
        if (start_len == ONE) begin
          irq_o   = 1'b1;
          first_d = 1'b0;
        end else begin
          rem_d = start_len - ONE;
        end
      end else begin
        rem_d = rem_q - ONE;
        if (rem_q == ONE) begin
          irq_o   = 1'b1;
          first_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      first_q <= 1'b1;
    end else begin
      rem_q   <= rem_d;
      first_q <= first_d;
    end
  end

  AST_IRQ_NEEDS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (evt_i && enable_i)); // R7

  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (rem_q == '0 && first_q)); // R8

  AST_IRQ_ENDS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !first_q); // R5

  AST_PRELOAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !evt_i) |=> $stable(rem_q)); // R9
endmodule

// File: rtl/pwm_irq_decimator.sv
module pwm_irq_decimator #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             mode_i,
  input  logic             src_sel_i,
  input  logic             edge_sel_i,
  input  logic             carrier_uf_i,
  input  logic             reload_ctl_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             irq_o
);
  logic             evt;
  logic [CNT_W-1:0] len_full, len_first;

  pwm_dec_evt_sel u_evt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .mode_i       (mode_i),
    .src_sel_i    (src_sel_i),
    .edge_sel_i   (edge_sel_i),
    .carrier_uf_i (carrier_uf_i),
    .reload_ctl_i (reload_ctl_i),
    .evt_o        (evt)
  );

  pwm_dec_reload #(.CNT_W(CNT_W)) u_reload (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .len_full_o  (len_full),
    .len_first_o (len_first)
  );

  pwm_dec_count #(.CNT_W(CNT_W)) u_count (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .evt_i       (evt),
    .len_full_i  (len_full),
    .len_first_i (len_first),
    .irq_o       (irq_o)
  );

  AST_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !irq_o); // R8

  AST_MODE0_UF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !mode_i) |-> carrier_uf_i); // R1
endmodule

// File: tb/tb_pwm_irq_decimator.sv
module tb_pwm_irq_decimator;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i = 1'b0, mode_i = 1'b0, src_sel_i = 1'b0, edge_sel_i = 1'b0;
  logic carrier_uf_i = 1'b0, reload_ctl_i = 1'b0, wr_en_i = 1'b0;
  logic [CNT_W-1:0] wr_data_i = '0;
  logic irq_o;

  int checks = 0, failures = 0;
  string cur_req = "R10";

  // reference state
  int m_reload = 0, m_rem = 0, m_irq_count = 0;
  bit m_first = 1'b1, m_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_irq_decimator #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .mode_i(mode_i),
    .src_sel_i(src_sel_i), .edge_sel_i(edge_sel_i), .carrier_uf_i(carrier_uf_i),
    .reload_ctl_i(reload_ctl_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .irq_o(irq_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // evaluate the model for the current inputs, compare, then advance as at the next edge
  task automatic model_step();
    bit evt, exp_irq;
    int neff, len;
    exp_irq = 1'b0;
    evt = 1'b0;
    if (enable_i) begin
      if (!mode_i || !src_sel_i) evt = carrier_uf_i;
      else if (edge_sel_i)       evt = m_prev && !reload_ctl_i;
      else                       evt = !m_prev && reload_ctl_i;
    end
    if (!enable_i) begin
      m_rem = 0;
      m_first = 1'b1;
    end else if (evt) begin
      if (m_rem == 0) begin
        neff = (m_reload == 0) ? 1 : m_reload;
        len  = m_first ? ((neff == 1) ? 1 : neff - 1) : neff;
        if (len == 1) begin exp_irq = 1'b1; m_first = 1'b0; end
        else m_rem = len - 1;
      end else begin
        m_rem--;
        if (m_rem == 0) begin exp_irq = 1'b1; m_first = 1'b0; end
      end
    end
    check(cur_req, int'(irq_o), int'(exp_irq));
    if (exp_irq) m_irq_count++;
    m_prev = reload_ctl_i;
    if (wr_en_i) m_reload = int'(wr_data_i);
  endtask

  task automatic cycle();
    #1;
    model_step();
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic write_n(int n);
    wr_en_i = 1'b1;
    wr_data_i = CNT_W'(n);
    cycle();
  endtask

  // random stimulus phase; probabilities in percent
  task automatic run_phase(string req, int cycles, bit md, bit src, bit edg,
                           int uf_pct, int ctl_pct, int sel_noise);
    cur_req = req;
    mode_i = md; src_sel_i = src; edge_sel_i = edg;
    for (int i = 0; i < cycles; i++) begin
      carrier_uf_i = (($urandom % 100) < uf_pct);
      if (($urandom % 100) < ctl_pct) reload_ctl_i = ~reload_ctl_i;
      if (sel_noise != 0) begin
        src_sel_i  = $urandom % 2;
        edge_sel_i = $urandom % 2;
      end
      cycle();
    end
    carrier_uf_i = 1'b0;
  endtask

  // deterministic: count underflow events until the first irq
  task automatic first_irq_at(string req, int n, int exp_events);
    int got;
    cur_req = req;
    enable_i = 1'b0; cycle();
    write_n(n);
    enable_i = 1'b1; mode_i = 1'b0;
    got = 0;
    for (int i = 1; i <= 300; i++) begin
      carrier_uf_i = 1'b1;
      #1;
      if (irq_o && got == 0) got = i;
      model_step();
      @(negedge clk);
      if (got != 0) break;
    end
    carrier_uf_i = 1'b0;
    check(req, got, exp_events);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10", int'(irq_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    cur_req = "R10";
    carrier_uf_i = 1'b1;
    cycle();
    carrier_uf_i = 1'b0;
    enable_i = 1'b1; mode_i = 1'b0;
    carrier_uf_i = 1'b1;
    #1;
    check("R10", int'(irq_o), 1);  // reload 0 after reset acts as 1
    model_step();
    @(negedge clk);
    carrier_uf_i = 1'b0;

    // R5 first period n-1, then n
    first_irq_at("R5", 4, 3);
    base = m_irq_count;
    cur_req = "R5";
    for (int i = 0; i < 4; i++) begin carrier_uf_i = 1'b1; cycle(); end
    carrier_uf_i = 1'b0;
    check("R5", m_irq_count - base, 1);
    first_irq_at("R5", 7, 6);

    // R6: n = 1 and n = 0, back-to-back events
    first_irq_at("R6", 1, 1);
    first_irq_at("R6", 0, 1);
    cur_req = "R6";
    base = m_irq_count;
    for (int i = 0; i < 5; i++) begin carrier_uf_i = 1'b1; cycle(); end
    carrier_uf_i = 1'b0;
    check("R6", m_irq_count - base, 5);

    // R7: single-cycle pulse timing against dense and sparse events
    write_n(2);
    run_phase("R7", 200, 1'b0, 1'b0, 1'b0, 100, 0, 0);
    run_phase("R7", 200, 1'b0, 1'b0, 1'b0, 30, 0, 0);

    // R1: mode 0 ignores selects and control signal
    write_n(3);
    run_phase("R1", 600, 1'b0, 1'b1, 1'b1, 25, 50, 1);

    // R2: mode 1, underflow source
    write_n(5);
    run_phase("R2", 600, 1'b1, 1'b0, 1'b1, 25, 50, 0);

    // R3: rising edges of the control signal
    write_n(4);
    run_phase("R3", 800, 1'b1, 1'b1, 1'b0, 50, 40, 0);

    // R4: falling edges
    write_n(6);
    run_phase("R4", 800, 1'b1, 1'b1, 1'b1, 50, 40, 0);

    // R8: enable toggled mid-period
    cur_req = "R8";
    write_n(5);
    for (int k = 0; k < 20; k++) begin
      enable_i = 1'b1;
      run_phase("R8", 3 + ($urandom % 12), 1'b0, 1'b0, 1'b0, 60, 0, 0);
      enable_i = 1'b0;
      run_phase("R8", 1 + ($urandom % 4), 1'b0, 1'b0, 1'b0, 60, 30, 0);
    end
    enable_i = 1'b1;

    // R9: writes during periods
    cur_req = "R9";
    write_n(8);
    for (int k = 0; k < 60; k++) begin
      run_phase("R9", 4 + ($urandom % 10), 1'b0, 1'b0, 1'b0, 50, 0, 0);
      write_n(1 + ($urandom % 9));
    end
    // directed: write shorter value mid-period; current period keeps old length
    enable_i = 1'b0; cycle();
    write_n(6);
    enable_i = 1'b1;
    for (int i = 0; i < 5; i++) begin carrier_uf_i = 1'b1; cycle(); end  // first irq at 5th
    carrier_uf_i = 1'b1; cycle();                                         // starts full period of 6
    carrier_uf_i = 1'b0;
    write_n(2);
    base = m_irq_count;
    for (int i = 0; i < 4; i++) begin carrier_uf_i = 1'b1; cycle(); end
    carrier_uf_i = 1'b0;
    check("R9", m_irq_count - base, 0);
    carrier_uf_i = 1'b1;
    #1;
    check("R9", int'(irq_o), 1);
    model_step();
    @(negedge clk);
    carrier_uf_i = 1'b0;

    // mixed random soak
    for (int k = 0; k < 40; k++) begin
      if (($urandom % 4) == 0) write_n($urandom % 10);
      enable_i = (($urandom % 8) != 0);
      run_phase("R7", 50, $urandom % 2, $urandom % 2, $urandom % 2, 30, 30, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule